// File: doc/BRIEF.md
# Boot Vector Remap and Abort Decoder

This block sits between a 32-bit processor's bus master and its on-chip memories and peripherals. For each access it decides which target region receives it: flash, SRAM, boot ROM, APB peripheral space or AHB peripheral space. It also produces the physical address to present to that target. An access that lands where nothing is implemented is not routed anywhere. Instead the block flags it as a prefetch abort when it is an instruction fetch, or as a data abort when it is a load or store.

The lowest 64 bytes of the address space (0x00 to 0x3F) hold the exception vectors plus 32 bytes of spare room. This window can be served from one of three sources. A two-bit mode register, written through a simple write port, selects the source: boot ROM, flash, or SRAM. Any reset restores the boot ROM source. A remapped source never loses its own home address; it stays reachable there as well.

The decoder is combinational from the access inputs. Its outputs are registered, so the response for an access presented in one cycle appears after the next rising clock edge.

Top module: `bvr_remap_decoder`

## Requirements
- R1: Reset clears every response output to zero and sets the map mode to boot, so after reset the vector window is served from the boot ROM.
- R2: A valid access outside the vector window drives rspSel one-hot after one clock edge, with bit 0 = flash (0x0 up to FLASH_BYTES), bit 1 = SRAM (0x4000_0000 up to SRAM_BYTES), bit 2 = boot ROM (the BOOT_BYTES just below 0x8000_0000), bit 3 = APB (0xE000_0000, 2 MB of 16 kB slots) and bit 4 = AHB (0xFFE0_0000, 2 MB of 16 kB slots). rspAddr then equals the input address.
- R3: In boot mode (mode code 2'b00), window addresses 0x00 to 0x3F select the boot ROM, with rspAddr = boot base + offset (boot base 0x7FFF_E000 by default).
- R4: In RAM mode (mode code 2'b10), window addresses select SRAM, with rspAddr = 0x4000_0000 + offset.
- R5: In flash mode (code 2'b01) and with the unused code 2'b11, window addresses select flash with the address unchanged.
- R6: Address 0x40 and above is never remapped, in any mode.
- R7: The boot ROM and SRAM stay selectable at their home addresses in every mode.
- R8: A valid access to an unimplemented hole aborts and selects nothing: rspPrefetchAbort when accFetch is 1, rspDataAbort otherwise. The holes are flash end to 0x3FFF_FFFF, SRAM end to boot base, 0x8000_0000 to 0xDFFF_FFFF, and 0xE020_0000 to 0xFFDF_FFFF.
- R9: Any instruction fetch to an assigned APB or AHB slot raises rspPrefetchAbort and selects nothing.
- R10: A data access to an unassigned peripheral slot raises rspDataAbort. Any offset inside an assigned slot selects that space without abort. By default the assigned APB slots are 0–4, 7–11, 13, 23, 26, 28, 29 and 127, and the only assigned AHB slot is 127.
- R11: When accValid is low, the next response has rspValid, rspSel, both abort flags and rspAddr all zero. rspValid follows accValid with one cycle of latency.
- R12: A mode write changes the mapping only for accesses presented after the clock edge that stores it. An access in the same cycle as the write uses the old mode.
- R13: Every valid response carries exactly one of the five select bits or one abort flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeWrEn | input | 1 | Write strobe for the map mode register |
| modeWrData | input | 2 | New map mode code |
| accValid | input | 1 | Access present this cycle |
| accAddr | input | 32 | Access address |
| accFetch | input | 1 | 1 = instruction fetch, 0 = data access |
| rspValid | output | 1 | Response valid (one cycle after accValid) |
| rspSel | output | 5 | One-hot target region select |
| rspAddr | output | 32 | Translated physical address |
| rspPrefetchAbort | output | 1 | Fetch to an illegal or peripheral address |
| rspDataAbort | output | 1 | Data access to an illegal address |

## Verification
The decoder is tried with directed addresses on both sides of every region edge. These include the last byte of flash, SRAM and boot ROM, the first byte past each, and 0x3F against 0x40 at the window edge. These separate off-by-one errors in the range compares from errors in the window width. Each window address is replayed in all four mode codes, and once in the same cycle as a mode write, to tell remap-source errors apart from mode timing errors. Fetch and data pairs on the same hole and peripheral addresses distinguish the two abort kinds. A long random run then draws addresses near every region base under random mode writes and idle cycles, and compares each response with the behavioural model.

// File: rtl/bvr_pkg.sv
package bvr_pkg;

  localparam int unsigned REGION_COUNT = 5;
  localparam int unsigned SEL_FLASH = 0;
  localparam int unsigned SEL_SRAM  = 1;
  localparam int unsigned SEL_BOOT  = 2;
  localparam int unsigned SEL_APB   = 3;
  localparam int unsigned SEL_AHB   = 4;

  localparam logic [31:0] SRAM_BASE_ADDR = 32'h4000_0000;
  localparam logic [31:0] BOOT_TOP_ADDR  = 32'h8000_0000;
  localparam logic [31:0] APB_BASE_ADDR  = 32'hE000_0000;
  localparam logic [31:0] AHB_BASE_ADDR  = 32'hFFE0_0000;

  typedef enum logic [1:0] {
    MODE_BOOT  = 2'b00,
    MODE_FLASH = 2'b01,
    MODE_RAM   = 2'b10,
    MODE_SPARE = 2'b11
  } mapMode_e;

  typedef struct packed {
    logic                    valid;
    logic [REGION_COUNT-1:0] sel;
    logic                    remapBoot;
    logic                    remapSram;
    logic                    pAbort;
    logic                    dAbort;
  } bvrStrobe_t;

endpackage

// File: rtl/bvr_ctrl.sv
module bvr_ctrl
  import bvr_pkg::*;
#(
  parameter int unsigned FLASH_BYTES   = 32768,
  parameter int unsigned SRAM_BYTES    = 8192,
  parameter int unsigned BOOT_BYTES    = 8192,
  parameter int unsigned WINDOW_BYTES  = 64,
  parameter int unsigned PERIPH_SLOTS  = 128,
  parameter int unsigned SLOT_BYTES    = 16384,
  parameter logic [PERIPH_SLOTS-1:0] APB_SLOT_MASK = '1,
  parameter logic [PERIPH_SLOTS-1:0] AHB_SLOT_MASK = '1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        modeWrEn,
  input  logic [1:0]  modeWrData,
  input  logic        accValid,
  input  logic [31:0] accAddr,
  input  logic        accFetch,
  output bvrStrobe_t  strobe
);

  localparam int unsigned WIN_BITS    = $clog2(WINDOW_BYTES);
  localparam int unsigned SLOT_BITS   = $clog2(PERIPH_SLOTS);
  localparam int unsigned OFF_BITS    = $clog2(SLOT_BYTES);
  localparam int unsigned SPACE_BITS  = SLOT_BITS + OFF_BITS;
  localparam logic [31:0] FLASH_END   = 32'(FLASH_BYTES);
  localparam logic [31:0] SRAM_END    = SRAM_BASE_ADDR + 32'(SRAM_BYTES);
  localparam logic [31:0] BOOT_BASE   = BOOT_TOP_ADDR - 32'(BOOT_BYTES);
  localparam logic [31-SPACE_BITS:0] APB_TAG = APB_BASE_ADDR[31:SPACE_BITS];
  localparam logic [31-SPACE_BITS:0] AHB_TAG = AHB_BASE_ADDR[31:SPACE_BITS];

  mapMode_e modeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_BOOT;
    end else if (modeWrEn) begin
      modeQ <= mapMode_e'(modeWrData);
    end
  end

  logic                 inWindow;
  logic                 flashHit;
  logic                 sramHit;
  logic                 bootHit;
  logic                 apbSpace;
  logic                 ahbSpace;
  logic [SLOT_BITS-1:0] slotIdx;
  logic [PERIPH_SLOTS-1:0] apbSlotOk;
  logic [PERIPH_SLOTS-1:0] ahbSlotOk;
  logic                 apbHit;
  logic                 ahbHit;
  logic                 periphHit;

  for (genvar s = 0; s < PERIPH_SLOTS; s++) begin : g_slot
    assign apbSlotOk[s] = APB_SLOT_MASK[s];
    assign ahbSlotOk[s] = AHB_SLOT_MASK[s];
  end

  always_comb begin
    inWindow  = (accAddr[31:WIN_BITS] == '0);
    flashHit  = (accAddr < FLASH_END);
    sramHit   = (accAddr >= SRAM_BASE_ADDR) && (accAddr < SRAM_END);
    bootHit   = (accAddr >= BOOT_BASE) && (accAddr < BOOT_TOP_ADDR);
    apbSpace  = (accAddr[31:SPACE_BITS] == APB_TAG);
    ahbSpace  = (accAddr[31:SPACE_BITS] == AHB_TAG);
    slotIdx   = accAddr[SPACE_BITS-1:OFF_BITS];
    apbHit    = apbSpace && apbSlotOk[slotIdx];
    ahbHit    = ahbSpace && ahbSlotOk[slotIdx];
    periphHit = apbHit || ahbHit;
  end

  always_comb begin
    strobe           = '0;
    strobe.valid     = accValid;
    if (accValid) begin
      strobe.remapBoot = inWindow && (modeQ == MODE_BOOT);
      strobe.remapSram = inWindow && (modeQ == MODE_RAM);
      if (strobe.remapBoot) begin
        strobe.sel[SEL_BOOT] = 1'b1;
      end else if (strobe.remapSram) begin
        strobe.sel[SEL_SRAM] = 1'b1;
      end else if (flashHit) begin
        strobe.sel[SEL_FLASH] = 1'b1;
      end else if (sramHit) begin
        strobe.sel[SEL_SRAM] = 1'b1;
      end else if (bootHit) begin
        strobe.sel[SEL_BOOT] = 1'b1;
      end else if (periphHit && accFetch) begin
        strobe.pAbort = 1'b1;
      end else if (apbHit) begin
        strobe.sel[SEL_APB] = 1'b1;
      end else if (ahbHit) begin
        strobe.sel[SEL_AHB] = 1'b1;
      end else if (accFetch) begin
        strobe.pAbort = 1'b1;
      end else begin
        strobe.dAbort = 1'b1;
      end
    end
  end

endmodule

// File: rtl/bvr_dpath.sv
module bvr_dpath
  import bvr_pkg::*;
#(
  parameter int unsigned BOOT_BYTES   = 8192,
  parameter int unsigned WINDOW_BYTES = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  bvrStrobe_t              strobe,
  input  logic [31:0]             accAddr,
  output logic                    rspValid,
  output logic [REGION_COUNT-1:0] rspSel,
  output logic [31:0]             rspAddr,
  output logic                    rspPrefetchAbort,
  output logic                    rspDataAbort
);

  localparam int unsigned WIN_BITS  = $clog2(WINDOW_BYTES);
  localparam logic [31:0] BOOT_BASE = BOOT_TOP_ADDR - 32'(BOOT_BYTES);

  logic [31:0] winOffset;
  logic [31:0] xlatAddr;

  always_comb begin
    winOffset = {{(32-WIN_BITS){1'b0}}, accAddr[WIN_BITS-1:0]};
    if (strobe.remapBoot) begin
      xlatAddr = BOOT_BASE | winOffset;
    end else if (strobe.remapSram) begin
      xlatAddr = SRAM_BASE_ADDR | winOffset;
    end else begin
      xlatAddr = accAddr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid         <= 1'b0;
      rspSel           <= '0;
      rspAddr          <= '0;
      rspPrefetchAbort <= 1'b0;
      rspDataAbort     <= 1'b0;
    end else begin
      rspValid         <= strobe.valid;
      rspSel           <= strobe.sel;
      rspAddr          <= strobe.valid ? xlatAddr : '0;
      rspPrefetchAbort <= strobe.pAbort;
      rspDataAbort     <= strobe.dAbort;
    end
  end

endmodule

// File: rtl/bvr_remap_decoder.sv
module bvr_remap_decoder
  import bvr_pkg::*;
#(
  parameter int unsigned FLASH_BYTES  = 32768,
  parameter int unsigned SRAM_BYTES   = 8192,
  parameter int unsigned BOOT_BYTES   = 8192,
  parameter int unsigned WINDOW_BYTES = 64,
  parameter int unsigned PERIPH_SLOTS = 128,
  parameter int unsigned SLOT_BYTES   = 16384,
  parameter logic [PERIPH_SLOTS-1:0] APB_SLOT_MASK =
    128'h80000000_00000000_00000000_34802F9F,
  parameter logic [PERIPH_SLOTS-1:0] AHB_SLOT_MASK =
    128'h80000000_00000000_00000000_00000000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        modeWrEn,
  input  logic [1:0]  modeWrData,
  input  logic        accValid,
  input  logic [31:0] accAddr,
  input  logic        accFetch,
  output logic        rspValid,
  output logic [4:0]  rspSel,
  output logic [31:0] rspAddr,
  output logic        rspPrefetchAbort,
  output logic        rspDataAbort
);

  bvrStrobe_t strobe;

  bvr_ctrl #(
    .FLASH_BYTES  (FLASH_BYTES),
    .SRAM_BYTES   (SRAM_BYTES),
    .BOOT_BYTES   (BOOT_BYTES),
    .WINDOW_BYTES (WINDOW_BYTES),
    .PERIPH_SLOTS (PERIPH_SLOTS),
    .SLOT_BYTES   (SLOT_BYTES),
    .APB_SLOT_MASK(APB_SLOT_MASK),
    .AHB_SLOT_MASK(AHB_SLOT_MASK)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .modeWrEn  (modeWrEn),
    .modeWrData(modeWrData),
    .accValid  (accValid),
    .accAddr   (accAddr),
    .accFetch  (accFetch),
    .strobe    (strobe)
  );

  bvr_dpath #(
    .BOOT_BYTES  (BOOT_BYTES),
    .WINDOW_BYTES(WINDOW_BYTES)
  ) u_dpath (
    .clk             (clk),
    .rstN            (rstN),
    .strobe          (strobe),
    .accAddr         (accAddr),
    .rspValid        (rspValid),
    .rspSel          (rspSel),
    .rspAddr         (rspAddr),
    .rspPrefetchAbort(rspPrefetchAbort),
    .rspDataAbort    (rspDataAbort)
  );

endmodule

// File: rtl/bvr_checker.sv
module bvr_checker #(
  parameter int unsigned FLASH_BYTES = 32768
) (
  input logic        clk,
  input logic        rstN,
  input logic        accValid,
  input logic [31:0] accAddr,
  input logic        accFetch,
  input logic        rspValid,
  input logic [4:0]  rspSel,
  input logic [31:0] rspAddr,
  input logic        rspPrefetchAbort,
  input logic        rspDataAbort
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (rspSel == '0 && !rspPrefetchAbort && !rspDataAbort && rspAddr == '0)); // R11

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    accValid |=> rspValid); // R11

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ($countones({rspSel, rspPrefetchAbort, rspDataAbort}) == 1)); // R13

  AST_FETCH_PERIPH: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accFetch && accAddr[31:29] == 3'b111) |=> rspPrefetchAbort); // R9

  AST_HOLE_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !accFetch && accAddr[31:30] == 2'b10) |=> rspDataAbort); // R8

  AST_HIGH_NOREMAP: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accAddr[31:6] != '0) |=> (rspAddr == $past(accAddr))); // R6

  AST_FLASH_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspSel == 5'b00001) |-> (rspAddr < 32'(FLASH_BYTES))); // R5

endmodule

bind bvr_remap_decoder bvr_checker #(.FLASH_BYTES(FLASH_BYTES)) u_chk (
  .clk             (clk),
  .rstN            (rstN),
  .accValid        (accValid),
  .accAddr         (accAddr),
  .accFetch        (accFetch),
  .rspValid        (rspValid),
  .rspSel          (rspSel),
  .rspAddr         (rspAddr),
  .rspPrefetchAbort(rspPrefetchAbort),
  .rspDataAbort    (rspDataAbort)
);

// File: tb/bvr_remap_decoder_tb.sv
`timescale 1ns/1ps
module bvr_remap_decoder_tb;

  typedef struct packed {
    logic        v;
    logic [4:0]  sel;
    logic [31:0] a;
    logic        pa;
    logic        da;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeWrEn = 1'b0;
  logic [1:0]  modeWrData = 2'b00;
  logic        accValid = 1'b0;
  logic [31:0] accAddr = '0;
  logic        accFetch = 1'b0;
  logic        rspValid;
  logic [4:0]  rspSel;
  logic [31:0] rspAddr;
  logic        rspPrefetchAbort;
  logic        rspDataAbort;

  int   checks = 0;
  int   fails = 0;
  int   cycles = 0;
  bit   finished = 0;
  int   modelMode = 0;
  exp_t expQ[$];
  string tagQ[$];

  bvr_remap_decoder u_dut (
    .clk(clk), .rstN(rstN), .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .accValid(accValid), .accAddr(accAddr), .accFetch(accFetch),
    .rspValid(rspValid), .rspSel(rspSel), .rspAddr(rspAddr),
    .rspPrefetchAbort(rspPrefetchAbort), .rspDataAbort(rspDataAbort)
  );

  always #2 clk = ~clk;

  function automatic bit apbAssigned(int s);
    return s inside {0, 1, 2, 3, 4, 7, 8, 9, 10, 11, 13, 23, 26, 28, 29, 127};
  endfunction

  function automatic exp_t model(logic [31:0] a, logic f, logic v, int mode);
    exp_t e;
    longint unsigned ua;
    e = '0;
    if (!v) return e;
    ua = longint'(a);
    e.v = 1'b1;
    e.a = a;
    if (ua < 64 && mode == 0) begin
      e.sel = 5'b00100; e.a = 32'h7FFF_E000 + a; return e;
    end
    if (ua < 64 && mode == 2) begin
      e.sel = 5'b00010; e.a = 32'h4000_0000 + a; return e;
    end
    if (ua < 64'h8000) e.sel = 5'b00001;
    else if (ua >= 64'h4000_0000 && ua < 64'h4000_2000) e.sel = 5'b00010;
    else if (ua >= 64'h7FFF_E000 && ua < 64'h8000_0000) e.sel = 5'b00100;
    else if (ua >= 64'hE000_0000 && ua < 64'hE020_0000 &&
             apbAssigned(int'((ua - 64'hE000_0000) / 16384)))
      e.sel = f ? 5'b00000 : 5'b01000;
    else if (ua >= 64'hFFFF_C000)
      e.sel = f ? 5'b00000 : 5'b10000;
    if (e.sel == 5'b00000) begin
      if (f) e.pa = 1'b1; else e.da = 1'b1;
    end
    return e;
  endfunction

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic compareNow();
    exp_t e;
    exp_t got;
    string t;
    if (expQ.size() == 0) return;
    e = expQ.pop_front();
    t = tagQ.pop_front();
    got = {rspValid, rspSel, rspAddr, rspPrefetchAbort, rspDataAbort};
    checks++;
    if (got !== e) begin
      fails++;
      $display("FAIL %s: actual v=%b sel=%b a=%h pa=%b da=%b expected v=%b sel=%b a=%h pa=%b da=%b",
               t, got.v, got.sel, got.a, got.pa, got.da, e.v, e.sel, e.a, e.pa, e.da);
    end
  endtask

  // one cycle: check the previous access, then present a new one
  task automatic step(logic v, logic [31:0] a, logic f, logic we, logic [1:0] wd, string tag);
    @(negedge clk);
    compareNow();
    accValid = v; accAddr = a; accFetch = f; modeWrEn = we; modeWrData = wd;
    expQ.push_back(model(a, f, v, modelMode));
    tagQ.push_back(tag);
    if (we) modelMode = int'(wd);
  endtask

  task automatic acc(logic [31:0] a, logic f, string tag);
    step(1'b1, a, f, 1'b0, 2'b00, tag);
  endtask

  task automatic setMode(logic [1:0] m, string tag);
    step(1'b0, 32'h0, 1'b0, 1'b1, m, tag);
  endtask

  task automatic doReset(string tag);
    @(negedge clk);
    compareNow();
    rstN = 1'b0;
    accValid = 1'b0; modeWrEn = 1'b0;
    expQ.delete(); tagQ.delete();
    modelMode = 0;
    @(negedge clk);
    checks++;
    if ({rspValid, rspSel, rspAddr, rspPrefetchAbort, rspDataAbort} !== '0) begin
      fails++;
      $display("FAIL %s: actual v=%b sel=%b a=%h expected all zero", tag, rspValid, rspSel, rspAddr);
    end
    rstN = 1'b1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual cycles=%0d expected completion", cycles);
      report();
    end
  end

  initial begin
    logic [31:0] bases[12];
    bases = '{32'h0, 32'h7F00, 32'h3FFF_FF00, 32'h4000_1F00, 32'h7FFF_DF00, 32'h7FFF_FF00,
              32'hDFFF_FF00, 32'hE000_0000, 32'hE007_C000, 32'hE01F_C000, 32'hFFDF_FF00, 32'hFFFF_C000};
    repeat (3) @(negedge clk);
    doReset("R1 reset outputs");

    acc(32'h0000_0000, 1'b0, "R1 boot after reset");
    acc(32'h0000_003C, 1'b1, "R3 boot window top");
    acc(32'h0000_0040, 1'b1, "R6 window edge boot");
    acc(32'h7FFF_E000, 1'b0, "R7 boot home");
    acc(32'h4000_0000, 1'b0, "R7 sram home");
    step(1'b1, 32'h0000_0004, 1'b0, 1'b1, 2'b10, "R12 same cycle old mode");
    acc(32'h0000_0004, 1'b0, "R4 ram window");
    acc(32'h0000_003F, 1'b1, "R4 ram window last");
    acc(32'h0000_0040, 1'b0, "R6 window edge ram");
    acc(32'h7FFF_E004, 1'b0, "R7 boot home in ram mode");
    setMode(2'b01, "R11 idle write");
    acc(32'h0000_0010, 1'b0, "R5 flash mode");
    setMode(2'b11, "R11 idle write");
    acc(32'h0000_0010, 1'b1, "R5 spare code");
    acc(32'h0000_0040, 1'b0, "R6 window edge flash");
    acc(32'h4000_0010, 1'b0, "R7 sram home flash mode");

    acc(32'h0000_7FFF, 1'b0, "R2 flash last");
    acc(32'h4000_1FFF, 1'b1, "R2 sram last");
    acc(32'h7FFF_FFFF, 1'b0, "R2 boot last");
    acc(32'hE000_C010, 1'b0, "R2 apb");
    acc(32'hFFFF_F000, 1'b0, "R2 ahb");

    acc(32'h0000_8000, 1'b0, "R8 flash end data");
    acc(32'h0000_8000, 1'b1, "R8 flash end fetch");
    acc(32'h4000_2000, 1'b0, "R8 sram end");
    acc(32'h7FFF_DFFF, 1'b1, "R8 below boot");
    acc(32'h8000_0000, 1'b0, "R8 reserved high");
    acc(32'hDFFF_FFFF, 1'b1, "R8 reserved top");
    acc(32'hE020_0000, 1'b0, "R8 between peripheral spaces");

    acc(32'hE000_C000, 1'b1, "R9 fetch apb");
    acc(32'hFFFF_F000, 1'b1, "R9 fetch ahb");

    acc(32'hE001_4000, 1'b0, "R10 unassigned apb slot");
    acc(32'hE000_D000, 1'b0, "R10 offset inside assigned slot");
    acc(32'hFFE0_0000, 1'b0, "R10 unassigned ahb slot");
    acc(32'hE01F_C000, 1'b0, "R10 last apb slot");

    step(1'b0, 32'h0000_0000, 1'b1, 1'b0, 2'b00, "R11 idle");
    step(1'b0, 32'hE000_0000, 1'b0, 1'b0, 2'b00, "R11 idle");

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a;
      logic v;
      logic we;
      a  = bases[$urandom_range(0, 11)] + 32'($urandom_range(0, 255));
      v  = ($urandom_range(0, 9) != 0);
      we = ($urandom_range(0, 9) == 0);
      step(v, a, 1'($urandom_range(0, 1)), we, 2'($urandom_range(0, 3)),
           "R2 R13 random");
    end

    setMode(2'b10, "R11 idle write");
    doReset("R1 second reset");
    acc(32'h0000_0008, 1'b0, "R1 boot mode restored");
    step(1'b0, 32'h0, 1'b0, 1'b0, 2'b00, "R11 idle");
    @(negedge clk);
    compareNow();
    finished = 1;
    report();
  end

endmodule